// File: doc/BRIEF.md
# Strobe-Clocked Register Write Bridge

This block carries register writes from an external processor's parallel bus into a register bank that runs on the core clock. The processor's write strobe has no timing relation to that clock. The strobe itself clocks a small holding stage, which latches the data word and the target address. The same edge inverts a one-bit flag. In the core domain, that flag passes through a two-flop synchronizer. A change in its level produces a load pulse one clock wide. The pulse copies the held word into the addressed register.

The held word must stay unchanged until the copy is done, so writes need a minimum spacing. When the processor writes faster than the core clock can follow, the packing factor can be raised above one. The bridge then gathers that many narrow writes into one wide word and starts a single handoff after the last of them. The strobe domain has its own asynchronous reset, because the strobe does not run freely. The core domain uses a synchronous reset.

Top module: `strobe_write_bridge`

## Requirements
- R1: With PACK=1, every rising edge of `wr_strobe` causes exactly one `load_pulse` in the core domain.
- R2: The addressed register shows the new word no later than the fourth rising `clk` edge after the strobe edge. This assumes the strobe edge meets setup to the next clock edge and that writes are at least four clock periods apart.
- R3: `load_pulse` is high for exactly one `clk` cycle per handoff and is never high in two consecutive cycles.
- R4: A handoff writes the full held word into register `wr_addr`, which sits at bits [addr*W +: W] of `bank_q`, where W = DATA_W*PACK. All other registers keep their values.
- R5: A handoff whose address is NREG or higher still produces a load pulse but changes no register.
- R6: Writes take effect in order, so repeated writes to one address leave the last word written.
- R7: With PACK>1, beat k of a group (k counted from 0) lands at bits [k*DATA_W +: DATA_W] of the wide word. The address captured with the last beat selects the register. No load pulse and no register change occur before the last beat of the group.
- R8: While `rst` is high, `bank_q` is all zeros and `load_pulse` is low. While `wr_rst` is high, the held word, the beat position and the flag are all cleared.
- R9: `bank_q` does not change in any cycle that follows a cycle without a load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high core reset |
| wr_strobe | input | 1 | External write strobe; its rising edge captures a beat |
| wr_rst | input | 1 | Asynchronous active-high reset of the strobe domain |
| wr_addr | input | ADDR_W | Target register address, sampled on the strobe edge |
| wr_data | input | DATA_W | Write data beat, sampled on the strobe edge |
| load_pulse | output | 1 | One-cycle pulse marking a bank update |
| bank_q | output | NREG*DATA_W*PACK | Flattened register bank, register i at bits [i*W +: W] |

## Verification
If the flag and the synchronizer history fall out of step, the fault shows within two core cycles of the next write. It appears either as a missing or doubled `load_pulse` or as a wrong pulse count against the writes issued. A holding stage that is overwritten early, or a beat counter that is off by one, shows in `bank_q` at the fourth clock edge after the strobe. It appears as swapped or stale bytes in the packed word or as a write to the wrong register. The bench compares the whole bank after every write, so an error is reported at the write that caused it.

// File: rtl/strobe_bridge_pkg.sv
package strobe_bridge_pkg;

    // Width of a counter that must hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of synchronizer flops ahead of the history flop.
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/strb_capture.sv
module strb_capture
    import strobe_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned PACK   = 1,
    localparam int unsigned WIDE_W = DATA_W * PACK
) (
    input  logic              strobe,
    input  logic              srst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [WIDE_W-1:0] hold_data,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              flag
);

    generate
        if (PACK == 1) begin : g_direct
            // Each strobe edge is a complete write: hold it and flip the flag.
            always_ff @(posedge strobe or posedge srst) begin
                if (srst) begin
                    hold_data <= '0;
                    hold_addr <= '0;
                    flag      <= 1'b0;
                end else begin
                    hold_data <= data_in;
                    hold_addr <= addr_in;
                    flag      <= ~flag;
                end
            end
        end else begin : g_packed
            localparam int unsigned BEAT_W = cnt_w(PACK);
            localparam int unsigned ASM_W  = DATA_W * (PACK - 1);

            logic [BEAT_W-1:0] beat_q;
            logic [ASM_W-1:0]  asm_q;

            // Early beats gather in a staging word, so the held word stays
            // stable while the next group is arriving.
            always_ff @(posedge strobe or posedge srst) begin
                if (srst) begin
                    beat_q    <= '0;
                    asm_q     <= '0;
                    hold_data <= '0;
                    hold_addr <= '0;
                    flag      <= 1'b0;
                end else if (beat_q == BEAT_W'(PACK - 1)) begin
                    hold_data <= {data_in, asm_q};
                    hold_addr <= addr_in;
                    flag      <= ~flag;
                    beat_q    <= '0;
                end else begin
                    asm_q[beat_q*DATA_W +: DATA_W] <= data_in;
                    beat_q                         <= beat_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/flag_sync_pulse.sv
module flag_sync_pulse
    import strobe_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flag_in,
    output logic pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], flag_in};
            hist_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A level change between the last two settled samples marks one write.
    assign pulse = sync_q[SYNC_STAGES-1] ^ hist_q;

    // R3: a handoff pulse lasts exactly one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/core_reg_bank.sv
module core_reg_bank #(
    parameter int unsigned WIDE_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned NREG   = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [WIDE_W-1:0]      data,
    output logic [NREG*WIDE_W-1:0] bank_q
);

    logic [WIDE_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (load && addr == ADDR_W'(i)) regs[i] <= data;
            end
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flat
            assign bank_q[g*WIDE_W +: WIDE_W] = regs[g];

            // R4: a handoff touches only the addressed register
            a_r4_others_untouched: assert property (@(posedge clk) disable iff (rst)
                (load && addr != ADDR_W'(g)) |=> $stable(regs[g]));
        end
    endgenerate

    // R9: no load, no change
    a_r9_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(bank_q));

    // R5: an address beyond the bank leaves every register as it was
    a_r5_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (load && int'(addr) >= int'(NREG)) |=> $stable(bank_q));

    // R8: core reset clears the bank
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (bank_q == '0));

endmodule

// File: rtl/strobe_write_bridge.sv
module strobe_write_bridge
    import strobe_bridge_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned NREG   = 6,
    parameter int unsigned PACK   = 1,
    localparam int unsigned WIDE_W = DATA_W * PACK
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_strobe,
    input  logic                   wr_rst,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic                   load_pulse,
    output logic [NREG*WIDE_W-1:0] bank_q
);

    logic [WIDE_W-1:0] held_word;
    logic [ADDR_W-1:0] held_addr;
    logic              xfer_flag;

    strb_capture #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PACK   (PACK)
    ) u_capture (
        .strobe    (wr_strobe),
        .srst      (wr_rst),
        .addr_in   (wr_addr),
        .data_in   (wr_data),
        .hold_data (held_word),
        .hold_addr (held_addr),
        .flag      (xfer_flag)
    );

    flag_sync_pulse u_sync (
        .clk     (clk),
        .rst     (rst),
        .flag_in (xfer_flag),
        .pulse   (load_pulse)
    );

    core_reg_bank #(
        .WIDE_W (WIDE_W),
        .ADDR_W (ADDR_W),
        .NREG   (NREG)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (load_pulse),
        .addr   (held_addr),
        .data   (held_word),
        .bank_q (bank_q)
    );

    // R8: no handoff while the core is held in reset
    a_r8_no_pulse_in_reset: assert property (@(posedge clk)
        rst |=> !load_pulse);

endmodule

// File: tb/tb_strobe_write_bridge.sv
`timescale 1ns/1ps
module tb_strobe_write_bridge;

    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int NREG = 6;
    localparam int PK   = 2;
    localparam int WB   = DW * PK;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, srst;
    logic stb_a, stb_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [DW-1:0] data_a, data_b;
    logic pulse_a, pulse_b;
    logic [NREG*DW-1:0] bank_a;
    logic [NREG*WB-1:0] bank_b;

    strobe_write_bridge #(.DATA_W(DW), .ADDR_W(AW), .NREG(NREG), .PACK(1)) dut (
        .clk(clk), .rst(rst), .wr_strobe(stb_a), .wr_rst(srst),
        .wr_addr(addr_a), .wr_data(data_a), .load_pulse(pulse_a), .bank_q(bank_a));

    strobe_write_bridge #(.DATA_W(DW), .ADDR_W(AW), .NREG(NREG), .PACK(PK)) dut_pack (
        .clk(clk), .rst(rst), .wr_strobe(stb_b), .wr_rst(srst),
        .wr_addr(addr_b), .wr_data(data_b), .load_pulse(pulse_b), .bank_q(bank_b));

    int checks = 0, failures = 0;
    int npa = 0, npb = 0;
    int expa = 0, expb = 0;
    bit done = 0;

    logic [DW-1:0] ma [NREG];
    logic [WB-1:0] mb [NREG];
    int bb = 0;
    logic [DW-1:0] asm_b;

    // pulse counters, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_a) npa++;
            if (pulse_b) npb++;
        end
    end

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_bank_a(input string req);
        int bad = -1;
        checks++;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && bank_a[i*DW +: DW] !== ma[i]) bad = i;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s: reg%0d actual=%h expected=%h", req, bad,
                     bank_a[bad*DW +: DW], ma[bad]);
        end
    endtask

    task automatic check_bank_b(input string req);
        int bad = -1;
        checks++;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && bank_b[i*WB +: WB] !== mb[i]) bad = i;
        if (bad >= 0) begin
            failures++;
            $display("FAIL %s: reg%0d actual=%h expected=%h", req, bad,
                     bank_b[bad*WB +: WB], mb[bad]);
        end
    endtask

    task automatic wr_a(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
        @(negedge clk);
        #($urandom_range(0, 2));
        addr_a = a; data_a = d;
        #0.3 stb_a = 1'b1;
        #1   stb_a = 1'b0;
        if (int'(a) < NREG) ma[a] = d;
        expa++;
        repeat (gap) @(posedge clk);
        #1;
    endtask

    task automatic wr_b(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
        @(negedge clk);
        #($urandom_range(0, 2));
        addr_b = a; data_b = d;
        #0.3 stb_b = 1'b1;
        #1   stb_b = 1'b0;
        if (bb == PK - 1) begin
            if (int'(a) < NREG) mb[a] = {d, asm_b};
            expb++;
            bb = 0;
        end else begin
            asm_b[bb*DW +: DW] = d;
            bb++;
        end
        repeat (gap) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; srst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        for (int i = 0; i < NREG; i++) begin ma[i] = '0; mb[i] = '0; end
        bb = 0;
        check_bank_a("R8 reset bank_a");
        check_bank_b("R8 reset bank_b");
        check_int("R8 pulse low in reset", int'(pulse_a | pulse_b), 0);
        rst = 1'b0; srst = 1'b0;
        npa = 0; npb = 0; expa = 0; expb = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        stb_a = 0; stb_b = 0; addr_a = 0; addr_b = 0; data_a = 0; data_b = 0;
        asm_b = '0;
        do_reset();

        // directed, unpacked
        wr_a(3'd0, 8'hA5, 4);
        check_bank_a("R2 first write at minimum spacing");
        check_int("R1 one pulse per strobe", npa, expa);
        wr_a(3'd5, 8'hFF, 4);
        check_bank_a("R4 top register full word");
        wr_a(3'd6, 8'h3C, 5);
        check_bank_a("R5 address 6 ignored");
        wr_a(3'd7, 8'hC3, 5);
        check_bank_a("R5 address 7 ignored");
        check_int("R5 pulse still issued", npa, expa);
        wr_a(3'd2, 8'h11, 4);
        wr_a(3'd2, 8'h22, 4);
        check_bank_a("R6 last write wins");
        repeat (6) @(posedge clk);
        #1;
        check_bank_a("R9 idle bank stable");
        check_int("R3 no extra pulses while idle", npa, expa);

        // random, unpacked
        for (int n = 0; n < 40; n++) begin
            wr_a(AW'($urandom_range(0, 7)), DW'($urandom), $urandom_range(4, 9));
            check_bank_a("R4 random write");
            check_int("R1 random pulse count", npa, expa);
        end

        // directed, packed
        wr_b(3'd2, 8'h11, 6);
        check_bank_b("R7 first beat changes nothing");
        check_int("R7 no pulse before last beat", npb, expb);
        wr_b(3'd3, 8'h22, 4);
        check_bank_b("R7 beat order and last-beat address");
        check_int("R7 one pulse per group", npb, expb);

        // random, packed: early beats may come faster
        for (int n = 0; n < 30; n++) begin
            wr_b(AW'($urandom_range(0, 7)), DW'($urandom), (bb == PK - 1) ? $urandom_range(4, 7)
                                                                          : $urandom_range(2, 4));
            if (bb == 0) begin
                check_bank_b("R7 random packed group");
                check_int("R7 random packed pulse count", npb, expb);
            end
        end

        // reset in the middle of a packed group, then resume
        wr_b(3'd1, 8'h99, 3);
        do_reset();
        wr_b(3'd4, 8'h0F, 3);
        wr_b(3'd4, 8'hF0, 4);
        check_bank_b("R8 strobe reset restarts beat count");
        wr_a(3'd1, 8'h5A, 4);
        check_bank_a("R8 write after reset");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule